// File: doc/BRIEF.md
# Byte/Word Add-And Unit with Status Flags

This block is one arithmetic slice of a processor datapath. Each accepted operation either adds two operands or takes their bitwise AND. A width select picks 8-bit or 16-bit operation for every operation independently. The block returns a result ready for write-back and a new status word. The status word is rebuilt from the incoming status word. The arithmetic flags are recomputed by the rules of the chosen operation, and the three control flags (direction, interrupt enable and trap) are copied through untouched.

Operands arrive on a single-beat input strobe. The block takes one operation on every cycle in which the strobe is high and never applies back-pressure, so there is no ready pin. The result, the status word and a one-cycle completion pulse appear together on the next rising edge. Between operations the outputs keep the last values they registered.

The status word is 9 bits wide and packed as follows: bit 0 carry, bit 1 parity, bit 2 nibble carry, bit 3 zero, bit 4 sign, bit 5 overflow, bit 6 direction, bit 7 interrupt enable, bit 8 trap.

Top module: `alu_bw`

## Requirements
- R1: With `op_sel`=0 (add), the registered result equals `opa + opb`, truncated to the selected width. Operands may be read as signed or unsigned.
- R2: With `op_sel`=1 (and), the registered result is the bitwise AND of `opa` and `opb` for the selected width.
- R3: With `wide`=0 (byte), only bits 7:0 of the operands take part, and result bits 15:8 are zero.
- R4: Carry (bit 0) is the carry out of bit 7 for byte adds and out of bit 15 for word adds. It is always 0 after an AND.
- R5: Overflow (bit 5) is 1 after an add when both operands have the same sign bit (bit 7 or bit 15) and the result's sign bit differs from it. It is always 0 after an AND.
- R6: Nibble carry (bit 2) is the carry out of bit 3 into bit 4 after an add. After an AND its value is unspecified.
- R7: Parity (bit 1) is 1 when result bits 7:0 hold an even number of ones, for both widths.
- R8: Sign (bit 4) is the result's top bit for the selected width. Zero (bit 3) is 1 exactly when all result bits of the selected width are 0.
- R9: Direction, interrupt enable and trap (bits 8:6) of `flags_out` equal those bits of `flags_in` as sampled with the operation.
- R10: Result and flags are registered on the rising edge on which `in_valid` is high. `done` is high for exactly the following cycle. With `in_valid` low, the outputs hold their values and input changes have no effect.
- R11: A synchronous active-high `rst` clears `res_out`, `flags_out` and `done`, and it takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe, accepted every cycle it is high |
| op_sel | input | 1 | 0 = add, 1 = and |
| wide | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| opa | input | 16 | Destination operand |
| opb | input | 16 | Source operand |
| flags_in | input | 9 | Current status word |
| res_out | output | 16 | Registered result |
| flags_out | output | 9 | Registered new status word |
| done | output | 1 | One-cycle pulse marking fresh outputs |

## Verification
Every output of an operation is due exactly one rising edge after the cycle in which `in_valid` was high. The bench drives each operation on a falling edge, lowers the strobe on the next falling edge, and compares result, every flag and `done` at that same moment, half a clock after the registering edge. It then idles for one more cycle while scrambling the operand inputs, and confirms that `done` has fallen and the outputs held. The nibble-carry flag is compared only for add operations.

// File: rtl/alu_bw_pkg.sv
package alu_bw_pkg;
  localparam int FLAG_W = 9;
  localparam int FC = 0;  // carry
  localparam int FP = 1;  // parity
  localparam int FA = 2;  // nibble carry
  localparam int FZ = 3;  // zero
  localparam int FS = 4;  // sign
  localparam int FO = 5;  // overflow
  localparam int FD = 6;  // direction
  localparam int FI = 7;  // interrupt enable
  localparam int FT = 8;  // trap

  typedef enum logic {OP_ADD = 1'b0, OP_AND = 1'b1} alu_op_e;
endpackage

// File: rtl/alu_bw_add.sv
module alu_bw_add #(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int NW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         wide,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ov,
  output logic         ac
);
  logic [W:0]  full;
  logic [BW:0] low;
  logic [NW:0] nib;
  logic        a_top, b_top, s_top;

  always_comb begin
    full  = {1'b0, a} + {1'b0, b};
    low   = {1'b0, a[BW-1:0]} + {1'b0, b[BW-1:0]};
    nib   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]};
    sum   = full[W-1:0];
    a_top = wide ? a[W-1] : a[BW-1];
    b_top = wide ? b[W-1] : b[BW-1];
    s_top = wide ? full[W-1] : full[BW-1];
    cy    = wide ? full[W] : low[BW];
    ov    = (a_top == b_top) && (s_top != a_top);
    ac    = nib[NW];
  end
endmodule

// File: rtl/alu_bw_and.sv
module alu_bw_and #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign y[i] = a[i] & b[i];
    end
  endgenerate
endmodule

// File: rtl/alu_bw_flags.sv
module alu_bw_flags
  import alu_bw_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  alu_op_e           op,
  input  logic              wide,
  input  logic [W-1:0]      raw,
  input  logic              add_cy,
  input  logic              add_ov,
  input  logic              add_ac,
  input  logic [FLAG_W-1:0] fin,
  output logic [W-1:0]      res,
  output logic [FLAG_W-1:0] fout
);
  localparam int HW = W - BW;

  always_comb begin
    res  = wide ? raw : {{HW{1'b0}}, raw[BW-1:0]};
    fout = fin;
    fout[FP] = ~^res[BW-1:0];
    fout[FZ] = (res == '0);
    fout[FS] = wide ? res[W-1] : res[BW-1];
    if (op == OP_ADD) begin
      fout[FC] = add_cy;
      fout[FO] = add_ov;
      fout[FA] = add_ac;
    end else begin
      fout[FC] = 1'b0;
      fout[FO] = 1'b0;
      fout[FA] = 1'b0;
    end
  end
endmodule

// File: rtl/alu_bw.sv
module alu_bw
  import alu_bw_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int NW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sel,
  input  logic              wide,
  input  logic [W-1:0]      opa,
  input  logic [W-1:0]      opb,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [W-1:0]      res_out,
  output logic [FLAG_W-1:0] flags_out,
  output logic              done
);
  alu_op_e           op;
  logic [W-1:0]      sum, andv, raw, res_n;
  logic              cy, ov, ac;
  logic [FLAG_W-1:0] fl_n;

  assign op  = alu_op_e'(op_sel);
  assign raw = (op == OP_ADD) ? sum : andv;

  alu_bw_add #(.W(W), .BW(BW), .NW(NW)) u_add (
    .a(opa), .b(opb), .wide(wide), .sum(sum), .cy(cy), .ov(ov), .ac(ac)
  );

  alu_bw_and #(.W(W)) u_and (.a(opa), .b(opb), .y(andv));

  alu_bw_flags #(.W(W), .BW(BW)) u_flags (
    .op(op), .wide(wide), .raw(raw), .add_cy(cy), .add_ov(ov), .add_ac(ac),
    .fin(flags_in), .res(res_n), .fout(fl_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      flags_out <= '0;
      done      <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        res_out   <= res_n;
        flags_out <= fl_n;
      end
    end
  end

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!done && $stable(res_out) && $stable(flags_out)));
  assert_and_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (done && $past(op_sel)) |-> (!flags_out[FC] && !flags_out[FO]));
  assert_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags_out[FT:FD] == $past(flags_in[FT:FD])));
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(wide)) |-> (res_out[W-1:BW] == '0));
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags_out[FZ] == (res_out == '0)));
endmodule

// File: tb/alu_bw_bench.sv
module alu_bw_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_sel = 1'b0;
  logic        wide = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic [8:0]  flags_in = '0;
  logic [15:0] res_out;
  logic [8:0]  flags_out;
  logic        done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alu_bw u_alu_bw (.clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .wide(wide), .opa(opa), .opb(opb), .flags_in(flags_in),
    .res_out(res_out), .flags_out(flags_out), .done(done));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: returns {flags, result}
  function automatic logic [24:0] model(input logic o, input logic w,
      input logic [15:0] a, input logic [15:0] b, input logic [8:0] fi);
    logic [15:0] r; logic [8:0] f; int s; int top; int ones;
    f = fi;
    top = w ? 15 : 7;
    if (!w) begin a = {8'h00, a[7:0]}; b = {8'h00, b[7:0]}; end
    if (o == 1'b0) begin
      s = int'(a) + int'(b);
      r = w ? s[15:0] : {8'h00, s[7:0]};
      f[0] = w ? s[16] : s[8];
      f[5] = (a[top] == b[top]) && (r[top] != a[top]);
      f[2] = ((int'(a[3:0]) + int'(b[3:0])) > 15);
    end else begin
      r = a & b;
      f[0] = 1'b0; f[5] = 1'b0; f[2] = 1'b0;
    end
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    f[1] = (ones % 2 == 0);
    f[4] = r[top];
    f[3] = (r == 16'h0000);
    return {f, r};
  endfunction

  task automatic run_op(input logic o, input logic w, input logic [15:0] a,
      input logic [15:0] b, input logic [8:0] fi);
    logic [24:0] e; logic [15:0] hr; logic [8:0] hf;
    e = model(o, w, a, b, fi);
    @(negedge clk);
    op_sel = o; wide = w; opa = a; opb = b; flags_in = fi; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 done", 32'(done), 32'd1);
    if (o == 1'b0) chk("R1 sum", 32'(res_out), 32'(e[15:0]));
    else           chk("R2 and", 32'(res_out), 32'(e[15:0]));
    if (!w) chk("R3 upper byte", 32'(res_out[15:8]), 32'd0);
    chk("R4 carry", 32'(flags_out[0]), 32'(e[16]));
    chk("R5 overflow", 32'(flags_out[5]), 32'(e[21]));
    if (o == 1'b0) chk("R6 nibble carry", 32'(flags_out[2]), 32'(e[18]));
    chk("R7 parity", 32'(flags_out[1]), 32'(e[17]));
    chk("R8 sign", 32'(flags_out[4]), 32'(e[20]));
    chk("R8 zero", 32'(flags_out[3]), 32'(e[19]));
    chk("R9 control flags", 32'(flags_out[8:6]), 32'(e[24:22]));
    hr = res_out; hf = flags_out;
    opa = ~a; opb = $urandom(); flags_in = ~fi; op_sel = ~o;
    @(negedge clk);
    chk("R10 done low", 32'(done), 32'd0);
    chk("R10 hold", {7'd0, hf, hr}, {7'd0, flags_out, res_out});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    in_valid = 1'b1; opa = 16'hFFFF; opb = 16'h0001; flags_in = 9'h1FF;
    repeat (3) @(negedge clk);
    chk("R11 reset result", 32'(res_out), 32'd0);
    chk("R11 reset flags", 32'(flags_out), 32'd0);
    chk("R11 reset done", 32'(done), 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    run_op(1'b0, 1'b0, 16'h007F, 16'h0001, 9'h000);
    run_op(1'b0, 1'b0, 16'hAAFF, 16'h0001, 9'h1C0);
    run_op(1'b0, 1'b1, 16'h7FFF, 16'h0001, 9'h040);
    run_op(1'b0, 1'b1, 16'hFFFF, 16'h0001, 9'h080);
    run_op(1'b0, 1'b0, 16'h000F, 16'h0001, 9'h100);
    run_op(1'b0, 1'b0, 16'h0080, 16'h0080, 9'h03F);
    run_op(1'b0, 1'b1, 16'h8000, 16'h8000, 9'h000);
    run_op(1'b1, 1'b1, 16'hFFFF, 16'h0000, 9'h1FF);
    run_op(1'b1, 1'b0, 16'hF0F3, 16'hFF81, 9'h03F);
    run_op(1'b1, 1'b1, 16'h8F0F, 16'hFFFF, 9'h000);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv;
      rv = $urandom();
      run_op(rv[0], rv[1], 16'($urandom()), 16'($urandom()), 9'($urandom()));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule